// File: doc/BRIEF.md
# Trace Capture Buffer

This block is a logic-analyzer style capture store for an embedded processor. While capture is on, every trace word offered on the input port is written into a circular RAM and the write index moves forward. Once the RAM is full, the newest word overwrites the oldest. Software controls the block through one control/status word, and it collects results through a separate data word.

To collect a trace, software turns capture off. It then reads the write index from the control word. That index names the oldest entry. Software then issues one read request per entry. Each request carries a read index, starting from the write index and counting upward. Hardware fetches the addressed word into the data register and clears the request bit. When the dump is finished, software turns capture back on, and recording continues from where it stopped.

The depth is a parameter. It must be a power of two no larger than 4096, and the default is 2048 words. The control word has these fields: capture-on at bit 0, read request at bit 1, read index at bits 13:2, write index at bits 27:16 (read-only) and packed program-counter mode at bit 30. The mode bit is stored for the decoder that reads the trace. It does not change how words are stored.

Top module: `trace_capture_buf`

## Requirements
- R1: Reset clears every stored field. After reset the control word reads 0, which means capture off, request 0, read index 0, write index 0 and mode 0. The data register also reads 0.
- R2: While bit 0 is 1, each cycle with trace_valid high writes trace_word at the current write index, and the index goes up by one. While bit 0 is 0, trace words are dropped and the write index holds.
- R3: The write index reads back in control bits 27:16, zero-extended. It wraps to 0 after reaching DEPTH-1.
- R4: Writing the control word with bit 1 set and bit 0 clear loads the RAM word at the read index into the data register one cycle after the write. In that same cycle bit 1 reads back as 0.
- R5: The read index reads back in bits 13:2 exactly as written. The RAM entry it selects is the index modulo DEPTH.
- R6: A read request written while bit 0 is 1 does nothing to the data register, and bit 1 still clears one cycle later.
- R7: Bit 30 reads back as written. It has no effect on capture or on the write index.
- R8: After capture is turned off and then on again, capture continues at the held write index, and stored entries stay as they were.
- R9: Reading DEPTH entries from index w, w+1, …, where w is the frozen write index, returns the last DEPTH captured words from oldest to newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_valid | input | 1 | Trace word present this cycle |
| trace_word | input | 32 | Trace word to record |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word readback, including the write index |
| data_rdata | output | 32 | Data register holding the last fetched entry |

## Verification
The hardest state to reach is a buffer that has wrapped and then been frozen and resumed. In that state the oldest entry sits in the middle of the RAM, and the readout must cross the end of the RAM back to index 0. The bench uses a depth of 16. It captures more than one full lap, stops, resumes, and captures again, so the write index ends at an odd offset. It then sweeps every entry from that index upward with read indices that run past the depth. A second sweep uses indices that are off by whole multiples of the depth, including the top value of the 12-bit field. The bench also mixes in requests made while capture is on, to confirm that the data register keeps its value.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    // Control word field positions (software decodes these)
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_REQ_BIT  = 1;
    localparam int CTL_RP_LSB   = 2;
    localparam int CTL_WP_LSB   = 16;
    localparam int CTL_MODE_BIT = 30;
    localparam int CTL_PTR_W    = 12;

    typedef logic [CTL_PTR_W-1:0] tcb_ptr_t;

    typedef struct packed {
        logic     pc_mode;
        tcb_ptr_t rd_ptr;
        logic     rd_req;
        logic     cap_en;
    } tcb_ctl_t;

    function automatic tcb_ctl_t unpack_ctl(input logic [31:0] w);
        tcb_ctl_t c;
        c.pc_mode = w[CTL_MODE_BIT];
        c.rd_ptr  = w[CTL_RP_LSB +: CTL_PTR_W];
        c.rd_req  = w[CTL_REQ_BIT];
        c.cap_en  = w[CTL_EN_BIT];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctl(input tcb_ctl_t c, input tcb_ptr_t wp);
        logic [31:0] w;
        w = '0;
        w[CTL_MODE_BIT]             = c.pc_mode;
        w[CTL_WP_LSB +: CTL_PTR_W]  = wp;
        w[CTL_RP_LSB +: CTL_PTR_W]  = c.rd_ptr;
        w[CTL_REQ_BIT]              = c.rd_req;
        w[CTL_EN_BIT]               = c.cap_en;
        return w;
    endfunction

endpackage

// File: rtl/tcb_regs.sv
module tcb_regs
    import tcb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output tcb_ctl_t    ctl,
    output logic        rd_fire
);

    tcb_ctl_t ctl_q;
    logic     unused_wbits;

    assign unused_wbits = ^{cfg_wdata[31], cfg_wdata[29:14]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (cfg_wr) begin
            ctl_q <= unpack_ctl(cfg_wdata);
        end else if (ctl_q.rd_req) begin
            ctl_q.rd_req <= 1'b0;
        end
    end

    assign ctl     = ctl_q;
    assign rd_fire = ctl_q.rd_req & ~ctl_q.cap_en;

    // R4
    req_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.rd_req && !cfg_wr) |=> !ctl_q.rd_req);

    // R7
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ($stable(ctl_q.pc_mode) && $stable(ctl_q.cap_en) && $stable(ctl_q.rd_ptr)));

endmodule

// File: rtl/tcb_wptr.sv
module tcb_wptr #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [AW-1:0] wptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] wptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (advance) begin
            wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
        end
    end

    assign wptr = wptr_q;

    // R2
    wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(wptr_q));

    // R3
    wptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && wptr_q == LAST) |=> (wptr_q == '0));

endmodule

// File: rtl/tcb_ram.sv
module tcb_ram #(
    parameter int DEPTH = 2048,
    parameter int DW    = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

    assign rd_data = rd_q;

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
    import tcb_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trace_valid,
    input  logic [31:0] trace_word,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] data_rdata
);

    tcb_ctl_t      ctl;
    logic          rd_fire;
    logic          capture;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rd_addr;

    tcb_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .ctl       (ctl),
        .rd_fire   (rd_fire)
    );

    assign capture = ctl.cap_en & trace_valid;

    tcb_wptr #(.DEPTH(DEPTH)) u_wptr (
        .clk     (clk),
        .rst     (rst),
        .advance (capture),
        .wptr    (wptr)
    );

    // Index is taken modulo the depth; all field bits take part
    assign rd_addr = AW'({1'b0, ctl.rd_ptr} % (CTL_PTR_W + 1)'(DEPTH));

    tcb_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (capture),
        .wr_addr (wptr),
        .wr_data (trace_word),
        .rd_en   (rd_fire),
        .rd_addr (rd_addr),
        .rd_data (data_rdata)
    );

    assign cfg_rdata = pack_ctl(ctl, CTL_PTR_W'(wptr));

    // R6
    live_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.rd_req && ctl.cap_en) |=> $stable(data_rdata));

    // R2
    frozen_wptr_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.cap_en |=> $stable(cfg_rdata[CTL_WP_LSB +: CTL_PTR_W]));

endmodule

// File: tb/trace_capture_buf_tb.sv
module trace_capture_buf_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trace_valid = 1'b0;
    logic [31:0] trace_word = '0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] data_rdata;

    int total = 0;
    int bad = 0;

    logic [31:0] m_mem [DEPTH];
    int          m_wp = 0;
    int          n_words = 0;
    logic        m_en = 0;
    logic        m_mode = 0;
    logic [11:0] m_rp = '0;
    logic [31:0] m_data = '0;

    always #2 clk = ~clk;

    trace_capture_buf #(.DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .trace_valid (trace_valid),
        .trace_word  (trace_word),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .data_rdata  (data_rdata)
    );

    function automatic logic [31:0] word_of(input int n);
        return (32'(n) * 32'h0100_0193) ^ 32'h00C0_DE00;
    endfunction

    function automatic logic [31:0] exp_ctl(input logic req);
        logic [31:0] w;
        w = '0;
        w[30]    = m_mode;
        w[27:16] = 12'(m_wp);
        w[13:2]  = m_rp;
        w[1]     = req;
        w[0]     = m_en;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic en, input logic req, input logic [11:0] rp, input logic mode);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = {1'b0, mode, 16'h0, 2'b00, 12'h0} | {18'h0, rp, req, en};
        @(negedge clk);
        cfg_wr    = 1'b0;
        m_en = en; m_mode = mode; m_rp = rp;
    endtask

    task automatic push(input int count);
        for (int k = 0; k < count; k++) begin
            @(negedge clk);
            trace_valid = 1'b1;
            trace_word  = word_of(n_words);
            if (m_en) begin
                m_mem[m_wp] = word_of(n_words);
                m_wp = (m_wp + 1) % DEPTH;
            end
            n_words++;
        end
        @(negedge clk);
        trace_valid = 1'b0;
    endtask

    // Frozen read: request is visible one cycle, data the next
    task automatic read_at(input logic [11:0] rp, input logic [31:0] exp, input string tag);
        write_ctl(1'b0, 1'b1, rp, m_mode);
        check({tag, " req pending"}, {31'h0, cfg_rdata[1]}, 32'h1);
        @(negedge clk);
        m_data = exp;
        check(tag, data_rdata, exp);
        check({tag, " req cleared"}, cfg_rdata, exp_ctl(1'b0));
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 ctl after reset", cfg_rdata, 32'h0);
        check("R1 data after reset", data_rdata, 32'h0);

        // R2 words dropped while capture off
        push(5);
        check("R2 wptr holds when off", cfg_rdata, exp_ctl(1'b0));

        // R2/R3 capture 5 words
        write_ctl(1'b1, 1'b0, 12'h0, 1'b0);
        push(5);
        check("R3 wptr after 5", cfg_rdata, exp_ctl(1'b0));

        // R4 frozen readout of each stored word
        write_ctl(1'b0, 1'b0, 12'h0, 1'b0);
        for (int i = 0; i < 5; i++) read_at(12'(i), m_mem[i], "R4 readout");

        // R8 resume and wrap past the end (25 captured total)
        write_ctl(1'b1, 1'b0, 12'h0, 1'b0);
        push(7);
        write_ctl(1'b0, 1'b0, 12'h0, 1'b0);
        push(3);
        check("R8 frozen wptr holds", cfg_rdata, exp_ctl(1'b0));
        write_ctl(1'b1, 1'b0, 12'h0, 1'b0);
        push(13);
        check("R3 wptr wrapped", cfg_rdata, exp_ctl(1'b0));
        write_ctl(1'b0, 1'b0, 12'h0, 1'b0);
        check("R3 wptr value 9", {20'h0, cfg_rdata[27:16]}, 32'd9);

        // R9 oldest-first sweep, index masked to 12 bits
        for (int i = 0; i < DEPTH; i++) begin
            logic [11:0] p;
            p = 12'((m_wp + i) & 12'hFFF);
            read_at(p, m_mem[(m_wp + i) % DEPTH], "R9 oldest-first");
        end

        // R5 index taken modulo depth, full field reads back
        read_at(12'(DEPTH + 2), m_mem[2], "R5 index plus depth");
        read_at(12'hFFF, m_mem[DEPTH - 1], "R5 top index");
        read_at(12'h800 + 12'd6, m_mem[6], "R5 high bit set");

        // R6 request while capturing is ignored
        write_ctl(1'b1, 1'b1, 12'h3, 1'b0);
        check("R6 req pending", {31'h0, cfg_rdata[1]}, 32'h1);
        @(negedge clk);
        check("R6 req cleared", cfg_rdata, exp_ctl(1'b0));
        check("R6 data unchanged", data_rdata, m_data);
        @(negedge clk);
        check("R6 data still unchanged", data_rdata, m_data);

        // R7 mode bit stored, capture unaffected
        write_ctl(1'b1, 1'b0, 12'h0, 1'b1);
        check("R7 mode readback", cfg_rdata, exp_ctl(1'b0));
        push(4);
        check("R7 capture in mode", cfg_rdata, exp_ctl(1'b0));
        write_ctl(1'b0, 1'b0, 12'h0, 1'b1);
        read_at(12'((m_wp + DEPTH - 1) % DEPTH), m_mem[(m_wp + DEPTH - 1) % DEPTH], "R7 newest word");

        // R1 reset during activity
        write_ctl(1'b1, 1'b0, 12'h5, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 ctl after mid reset", cfg_rdata, 32'h0);
        check("R1 data after mid reset", data_rdata, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule